// File: doc/BRIEF.md
# Pause Frame Flow Control Gate

This block serves one switch port. It watches the port's receive byte stream, picks out full-duplex flow-control frames that ask the link partner to stop sending, and runs a countdown timer. While that timer is active, a hold output tells the port's egress scheduler not to start another frame. Every flow-control frame is marked for discard, so no such frame leaves through another port.

Full-duplex pausing is active only when two conditions are both true. The first is a strap input sampled while reset is high. The second is the pause ability reported by the link negotiation. A second strap turns on a half-duplex congestion mode. In that mode the block forces a collision on every incoming frame while congestion is requested. After the configured number of forced collisions in a row, it lets one frame through so that an attached repeater does not partition the port.

The receive stream is byte-wide. `rx_sof` marks the first byte. `rx_eof` is a separate strobe one cycle after the last byte, and it carries the CRC verdict. The frame's first byte arrives first.

Top module: `pfc_gate`

## Requirements
- R1: In the cycle after reset has been high, `tx_hold`, `pkt_drop` and `force_col` are 0 and `col_count` is 0.
- R2: A frame is a control frame when all three of the following hold. Byte positions count from 0 at the `rx_sof` byte.
  - Bytes 0..5 are 01,80,C2,00,00,01.
  - Bytes 12..13 are 88,08.
  - Bytes 14..15 are 00,01.

  For every control frame, `pkt_drop` is 1 for exactly the one cycle after `rx_eof`. This holds whatever the CRC, the pause time or the enables are. For any other frame, `pkt_drop` stays 0.
- R3: A control frame whose bytes 16..17 are FF,FF, ended with `rx_crc_ok`=1 while pausing is enabled, raises `tx_hold` in the cycle after `rx_eof`, provided `tx_busy` is 0.
- R4: After a maximum-time frame, `tx_hold` stays high for MAX_QUANTA×QUANTUM_CYC cycles and then falls. A further maximum-time frame reloads the full count.
- R5: A control frame whose bytes 16..17 are 00,00, ended with good CRC, drops `tx_hold` in the cycle after `rx_eof`.
- R6: A control frame with bad CRC, or with any pause time other than 0000 or FFFF, leaves `tx_hold` and the timer unchanged.
- R7: Pausing is enabled only when the `strap_fc_en` value held during reset is 1 and `pause_ability` is 1. Changing the strap after reset has no effect. If `pause_ability` is 0 in a cycle, `tx_hold` is 0 in the next cycle, and the timer is cleared.
- R8: `tx_hold` only rises after a cycle in which `tx_busy` was 0. A frame already being sent finishes.
- R9: When the `strap_bp_en` value held during reset is 1 and `bp_req` is 1, each `rx_sof` with `col_count` below COL_LIMIT gives a one-cycle `force_col` pulse in the next cycle and adds one to `col_count`. At COL_LIMIT, the next `rx_sof` gives no pulse. That frame's `rx_eof` then returns `col_count` to 0.
- R10: When `bp_req` is 0, or the back-pressure strap held during reset is 0, `col_count` is 0 in the next cycle and `force_col` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while high |
| strap_fc_en | input | 1 | Full-duplex pause enable strap |
| strap_bp_en | input | 1 | Half-duplex back-pressure enable strap |
| pause_ability | input | 1 | Negotiated pause ability of the link |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_data | input | 8 | Receive byte |
| rx_eof | input | 1 | End-of-frame strobe, one cycle after the last byte |
| rx_crc_ok | input | 1 | CRC verdict, valid with `rx_eof` |
| tx_busy | input | 1 | Egress is in the middle of a frame |
| bp_req | input | 1 | Port congestion, requests back pressure |
| tx_hold | output | 1 | Do not start a new egress frame |
| pkt_drop | output | 1 | Discard the frame that just ended |
| force_col | output | 1 | Force a collision on the incoming frame |
| col_count | output | COL_W | Consecutive forced collisions |

## Verification
The bench sends frames that miss the control pattern by one field. A design that matched too loosely would raise `pkt_drop` on them. It also sends control frames with bad CRC or an odd pause time, which a careless design would let start or stop the hold. The bench times hold expiry on both sides of the programmed length and retriggers midway, so a design that ignored a reload would release early. It also changes the strap after reset and removes pause ability during a hold, which a design without the reset latch or the enable gate would get wrong. `tx_busy` is held high across a pause frame to catch a hold that cuts into a frame in flight. The collision run is driven to exactly COL_LIMIT and one past it, which exposes an off-by-one in the pass-through frame.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    localparam int POS_W     = 5;
    localparam int HDR_BYTES = 16;
    localparam int MIN_BYTES = 18;
    localparam int POS_TIME_HI = 16;
    localparam int POS_TIME_LO = 17;

    typedef struct packed {
        logic       care;
        logic [7:0] val;
    } exp_byte_t;

    typedef struct packed {
        logic is_ctrl;
        logic t_zero;
        logic t_max;
    } parse_res_t;

    // Expected header byte at a given position; address of sender is don't-care.
    function automatic exp_byte_t ctl_expect(input logic [POS_W-1:0] pos);
        exp_byte_t e;
        e.care = 1'b1;
        e.val  = 8'h00;
        case (pos)
            5'd0:  e.val = 8'h01;
            5'd1:  e.val = 8'h80;
            5'd2:  e.val = 8'hC2;
            5'd3:  e.val = 8'h00;
            5'd4:  e.val = 8'h00;
            5'd5:  e.val = 8'h01;
            5'd12: e.val = 8'h88;
            5'd13: e.val = 8'h08;
            5'd14: e.val = 8'h00;
            5'd15: e.val = 8'h01;
            default: e.care = 1'b0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pfc_rx_parser.sv
module pfc_rx_parser
    import pfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic       rx_sof,
    input  logic [7:0] rx_data,
    output parse_res_t res
);
    localparam logic [POS_W-1:0] POS_MAX = '1;

    logic [POS_W-1:0] pos_q, pos;
    logic             hdr_ok_q;
    logic             hi_ff_q, hi_00_q, lo_ff_q, lo_00_q;
    exp_byte_t        exp_b;
    logic             byte_ok;

    always_comb begin
        pos     = rx_sof ? '0 : pos_q;
        exp_b   = ctl_expect(pos);
        byte_ok = !exp_b.care || (rx_data == exp_b.val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= '0;
            hdr_ok_q <= 1'b0;
            hi_ff_q  <= 1'b0;
            hi_00_q  <= 1'b0;
            lo_ff_q  <= 1'b0;
            lo_00_q  <= 1'b0;
        end else if (rx_valid) begin
            pos_q    <= (pos == POS_MAX) ? pos : pos + 1'b1;
            hdr_ok_q <= (rx_sof | hdr_ok_q) & byte_ok;
            if (pos == POS_W'(POS_TIME_HI)) begin
                hi_ff_q <= (rx_data == 8'hFF);
                hi_00_q <= (rx_data == 8'h00);
            end
            if (pos == POS_W'(POS_TIME_LO)) begin
                lo_ff_q <= (rx_data == 8'hFF);
                lo_00_q <= (rx_data == 8'h00);
            end
        end
    end

    always_comb begin
        res.is_ctrl = hdr_ok_q && (pos_q >= POS_W'(HDR_BYTES));
        res.t_zero  = res.is_ctrl && (pos_q >= POS_W'(MIN_BYTES)) && hi_00_q && lo_00_q;
        res.t_max   = res.is_ctrl && (pos_q >= POS_W'(MIN_BYTES)) && hi_ff_q && lo_ff_q;
    end

endmodule

// File: rtl/pfc_pause_timer.sv
module pfc_pause_timer #(
    parameter int QUANTUM_CYC = 256,
    parameter int MAX_QUANTA  = 65535
) (
    input  logic clk,
    input  logic rst,
    input  logic fc_en,
    input  logic load_max,
    input  logic load_zero,
    input  logic tx_busy,
    output logic tx_hold
);
    localparam int REM_W = (MAX_QUANTA < 2) ? 1 : $clog2(MAX_QUANTA + 1);
    localparam int SUB_W = (QUANTUM_CYC < 2) ? 1 : $clog2(QUANTUM_CYC);

    logic [REM_W-1:0] rem_q, rem_d;
    logic [SUB_W-1:0] sub_q, sub_d;
    logic             hold_q, hold_d;

    always_comb begin
        rem_d = rem_q;
        sub_d = sub_q;
        if (!fc_en) begin
            rem_d = '0;
            sub_d = '0;
        end else if (load_max) begin
            rem_d = REM_W'(MAX_QUANTA);
            sub_d = '0;
        end else if (load_zero) begin
            rem_d = '0;
            sub_d = '0;
        end else if (rem_q != '0) begin
            if (sub_q == SUB_W'(QUANTUM_CYC - 1)) begin
                sub_d = '0;
                rem_d = rem_q - 1'b1;
            end else begin
                sub_d = sub_q + 1'b1;
            end
        end
        // hold may only rise while egress is idle
        hold_d = (rem_d != '0) && (hold_q || !tx_busy);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            sub_q  <= '0;
            hold_q <= 1'b0;
        end else begin
            rem_q  <= rem_d;
            sub_q  <= sub_d;
            hold_q <= hold_d;
        end
    end

    assign tx_hold = hold_q;

endmodule

// File: rtl/pfc_backpressure.sv
module pfc_backpressure #(
    parameter int COL_LIMIT = 48,
    parameter int COL_W     = $clog2(COL_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bp_on,
    input  logic             frame_start,
    input  logic             frame_end,
    output logic             force_col,
    output logic [COL_W-1:0] col_count
);
    logic [COL_W-1:0] cnt_q;
    logic             pass_q;
    logic             col_q;

    always_ff @(posedge clk) begin
        if (rst || !bp_on) begin
            cnt_q  <= '0;
            pass_q <= 1'b0;
            col_q  <= 1'b0;
        end else begin
            col_q <= 1'b0;
            if (frame_start) begin
                if (cnt_q == COL_W'(COL_LIMIT)) begin
                    pass_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                    col_q <= 1'b1;
                end
            end else if (frame_end && pass_q) begin
                cnt_q  <= '0;
                pass_q <= 1'b0;
            end
        end
    end

    assign force_col = col_q;
    assign col_count = cnt_q;

endmodule

// File: rtl/pfc_gate.sv
module pfc_gate
    import pfc_pkg::*;
#(
    parameter int QUANTUM_CYC = 256,
    parameter int MAX_QUANTA  = 65535,
    parameter int COL_LIMIT   = 48,
    localparam int COL_W      = $clog2(COL_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strap_fc_en,
    input  logic             strap_bp_en,
    input  logic             pause_ability,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic [7:0]       rx_data,
    input  logic             rx_eof,
    input  logic             rx_crc_ok,
    input  logic             tx_busy,
    input  logic             bp_req,
    output logic             tx_hold,
    output logic             pkt_drop,
    output logic             force_col,
    output logic [COL_W-1:0] col_count
);
    logic       fc_strap_q, bp_strap_q;
    logic       drop_q;
    parse_res_t res;
    logic       fc_en, good_end, load_max, load_zero;

    // straps are captured only while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            fc_strap_q <= strap_fc_en;
            bp_strap_q <= strap_bp_en;
        end
    end

    pfc_rx_parser u_parser (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_sof   (rx_sof),
        .rx_data  (rx_data),
        .res      (res)
    );

    always_comb begin
        fc_en     = fc_strap_q && pause_ability;
        good_end  = rx_eof && rx_crc_ok;
        load_max  = good_end && res.t_max;
        load_zero = good_end && res.t_zero;
    end

    always_ff @(posedge clk) begin
        if (rst) drop_q <= 1'b0;
        else     drop_q <= rx_eof && res.is_ctrl;
    end
    assign pkt_drop = drop_q;

    pfc_pause_timer #(
        .QUANTUM_CYC (QUANTUM_CYC),
        .MAX_QUANTA  (MAX_QUANTA)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .fc_en     (fc_en),
        .load_max  (load_max),
        .load_zero (load_zero),
        .tx_busy   (tx_busy),
        .tx_hold   (tx_hold)
    );

    pfc_backpressure #(
        .COL_LIMIT (COL_LIMIT),
        .COL_W     (COL_W)
    ) u_bp (
        .clk         (clk),
        .rst         (rst),
        .bp_on       (bp_strap_q && bp_req),
        .frame_start (rx_valid && rx_sof),
        .frame_end   (rx_eof),
        .force_col   (force_col),
        .col_count   (col_count)
    );

endmodule

// File: rtl/pfc_gate_chk.sv
module pfc_gate_chk #(
    parameter int COL_LIMIT = 48,
    parameter int COL_W     = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             pause_ability,
    input logic             rx_eof,
    input logic             rx_sof,
    input logic             tx_busy,
    input logic             bp_req,
    input logic             tx_hold,
    input logic             pkt_drop,
    input logic             force_col,
    input logic [COL_W-1:0] col_count
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!tx_hold && !pkt_drop && !force_col && col_count == '0));

    assert_drop_after_eof_R2: assert property (@(posedge clk) disable iff (rst)
        pkt_drop |-> $past(rx_eof));

    assert_hold_needs_ability_R7: assert property (@(posedge clk) disable iff (rst)
        !pause_ability |=> !tx_hold);

    assert_hold_rise_idle_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_hold) |-> !$past(tx_busy));

    assert_col_bound_R9: assert property (@(posedge clk) disable iff (rst)
        col_count <= COL_W'(COL_LIMIT));

    assert_col_after_sof_R9: assert property (@(posedge clk) disable iff (rst)
        force_col |-> $past(rx_sof));

    assert_col_release_R10: assert property (@(posedge clk) disable iff (rst)
        !bp_req |=> (col_count == '0 && !force_col));

endmodule

bind pfc_gate pfc_gate_chk #(.COL_LIMIT(COL_LIMIT), .COL_W(COL_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .pause_ability (pause_ability),
    .rx_eof        (rx_eof),
    .rx_sof        (rx_sof),
    .tx_busy       (tx_busy),
    .bp_req        (bp_req),
    .tx_hold       (tx_hold),
    .pkt_drop      (pkt_drop),
    .force_col     (force_col),
    .col_count     (col_count)
);

// File: tb/pfc_gate_tb.sv
`timescale 1ns/1ps
module pfc_gate_tb;
    localparam int QC    = 4;
    localparam int MAXQ  = 200;
    localparam int LIMIT = 48;
    localparam int CW    = $clog2(LIMIT + 1);
    localparam int HOLD_CYC = QC * MAXQ;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strap_fc_en = 1'b1, strap_bp_en = 1'b0, pause_ability = 1'b1;
    logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_crc_ok = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic tx_busy = 1'b0, bp_req = 1'b0;
    logic tx_hold, pkt_drop, force_col;
    logic [CW-1:0] col_count;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pfc_gate #(.QUANTUM_CYC(QC), .MAX_QUANTA(MAXQ), .COL_LIMIT(LIMIT)) u_dut (
        .clk(clk), .rst(rst), .strap_fc_en(strap_fc_en), .strap_bp_en(strap_bp_en),
        .pause_ability(pause_ability), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_data(rx_data), .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok), .tx_busy(tx_busy),
        .bp_req(bp_req), .tx_hold(tx_hold), .pkt_drop(pkt_drop), .force_col(force_col),
        .col_count(col_count)
    );

    typedef struct packed {
        logic        da_ok;
        logic        ty_ok;
        logic        op_ok;
        logic [15:0] ptime;
        logic        crc;
        logic        exp_drop;
        logic        exp_hold;
    } vec_t;

    localparam vec_t VECS [0:8] = '{
        '{1'b0, 1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b0, 1'b0},  // wrong DA
        '{1'b1, 1'b0, 1'b1, 16'hFFFF, 1'b1, 1'b0, 1'b0},  // wrong type
        '{1'b1, 1'b1, 1'b0, 16'hFFFF, 1'b1, 1'b0, 1'b0},  // wrong opcode
        '{1'b1, 1'b1, 1'b1, 16'h1234, 1'b1, 1'b1, 1'b0},  // odd time
        '{1'b1, 1'b1, 1'b1, 16'hFFFF, 1'b0, 1'b1, 1'b0},  // bad CRC
        '{1'b1, 1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b1, 1'b1},  // pause on
        '{1'b1, 1'b1, 1'b1, 16'h0005, 1'b1, 1'b1, 1'b1},  // odd time keeps hold
        '{1'b1, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b1},  // bad CRC zero keeps hold
        '{1'b1, 1'b1, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b0}   // pause off
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic fc, input logic bp);
        @(negedge clk);
        strap_fc_en = fc;
        strap_bp_en = bp;
        rst = 1'b1;
        cycles(3);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Returns at the negedge one cycle after rx_eof was sampled.
    task automatic send_frame(input logic da_ok, input logic ty_ok, input logic op_ok,
                              input logic [15:0] ptime, input logic crc);
        logic [7:0] b;
        for (int p = 0; p < 20; p++) begin
            case (p)
                0:  b = da_ok ? 8'h01 : 8'h03;
                1:  b = 8'h80;
                2:  b = 8'hC2;
                3:  b = 8'h00;
                4:  b = 8'h00;
                5:  b = 8'h01;
                12: b = ty_ok ? 8'h88 : 8'h08;
                13: b = ty_ok ? 8'h08 : 8'h00;
                14: b = 8'h00;
                15: b = op_ok ? 8'h01 : 8'h02;
                16: b = ptime[15:8];
                17: b = ptime[7:0];
                default: b = 8'h20 + 8'(p);
            endcase
            rx_valid = 1'b1;
            rx_sof   = (p == 0);
            rx_data  = b;
            @(negedge clk);
        end
        rx_valid  = 1'b0;
        rx_sof    = 1'b0;
        rx_eof    = 1'b1;
        rx_crc_ok = crc;
        @(negedge clk);
        rx_eof    = 1'b0;
        rx_crc_ok = 1'b0;
    endtask

    task automatic sof_only();
        rx_valid = 1'b1;
        rx_sof   = 1'b1;
        rx_data  = 8'h55;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof   = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog run did not complete");
        finish_run();
    end

    initial begin
        // R1 reset state
        do_reset(1'b1, 1'b0);
        check("R1 hold", tx_hold, 0);
        check("R1 drop", pkt_drop, 0);
        check("R1 col", force_col, 0);
        check("R1 count", col_count, 0);

        // R2 R3 R5 R6 vector table
        for (int i = 0; i < 9; i++) begin
            send_frame(VECS[i].da_ok, VECS[i].ty_ok, VECS[i].op_ok, VECS[i].ptime, VECS[i].crc);
            check($sformatf("R2 drop vec%0d", i), pkt_drop, VECS[i].exp_drop);
            check($sformatf("R3_R5_R6 hold vec%0d", i), tx_hold, VECS[i].exp_hold);
            @(negedge clk);
            check($sformatf("R2 drop pulse vec%0d", i), pkt_drop, 0);
            cycles(2);
        end

        // R4 expiry
        send_frame(1'b1, 1'b1, 1'b1, 16'hFFFF, 1'b1);
        cycles(HOLD_CYC - 10);
        check("R4 hold before expiry", tx_hold, 1);
        cycles(20);
        check("R4 hold after expiry", tx_hold, 0);

        // R4 retrigger reloads
        send_frame(1'b1, 1'b1, 1'b1, 16'hFFFF, 1'b1);
        cycles(600);
        send_frame(1'b1, 1'b1, 1'b1, 16'hFFFF, 1'b1);
        cycles(600);
        check("R4 reload keeps hold", tx_hold, 1);
        cycles(250);
        check("R4 reload expiry", tx_hold, 0);

        // R7 ability gating
        pause_ability = 1'b0;
        send_frame(1'b1, 1'b1, 1'b1, 16'hFFFF, 1'b1);
        check("R7 no ability no hold", tx_hold, 0);
        check("R7 drop still", pkt_drop, 1);
        pause_ability = 1'b1;
        send_frame(1'b1, 1'b1, 1'b1, 16'hFFFF, 1'b1);
        check("R7 ability hold", tx_hold, 1);
        pause_ability = 1'b0;
        @(negedge clk);
        check("R7 ability loss clears", tx_hold, 0);
        pause_ability = 1'b1;
        cycles(3);
        check("R7 timer cleared", tx_hold, 0);

        // R8 busy egress defers hold
        tx_busy = 1'b1;
        send_frame(1'b1, 1'b1, 1'b1, 16'hFFFF, 1'b1);
        check("R8 hold deferred", tx_hold, 0);
        cycles(3);
        check("R8 still deferred", tx_hold, 0);
        tx_busy = 1'b0;
        @(negedge clk);
        check("R8 hold after idle", tx_hold, 1);
        tx_busy = 1'b1;
        cycles(2);
        check("R8 hold kept while busy", tx_hold, 1);
        tx_busy = 1'b0;
        send_frame(1'b1, 1'b1, 1'b1, 16'h0000, 1'b1);
        check("R5 zero releases", tx_hold, 0);

        // R7 strap latched at reset only
        do_reset(1'b0, 1'b0);
        strap_fc_en = 1'b1;
        send_frame(1'b1, 1'b1, 1'b1, 16'hFFFF, 1'b1);
        check("R7 strap after reset ignored", tx_hold, 0);
        check("R2 drop with fc off", pkt_drop, 1);

        // R10 back pressure strap off
        bp_req = 1'b1;
        sof_only();
        check("R10 no strap no col", force_col, 0);
        check("R10 no strap count", col_count, 0);

        // R9 collision run
        do_reset(1'b1, 1'b1);
        bp_req = 1'b1;
        @(negedge clk);
        for (int k = 1; k <= LIMIT; k++) begin
            sof_only();
            if (k == 1 || k == LIMIT) begin
                check($sformatf("R9 col pulse %0d", k), force_col, 1);
                check($sformatf("R9 count %0d", k), col_count, k);
            end
            @(negedge clk);
            if (k == 1) check("R9 col one cycle", force_col, 0);
        end
        sof_only();
        check("R9 pass frame no col", force_col, 0);
        check("R9 count held", col_count, LIMIT);
        cycles(3);
        rx_eof = 1'b1;
        @(negedge clk);
        rx_eof = 1'b0;
        check("R9 count cleared after pass", col_count, 0);
        sof_only();
        check("R9 resumes col", force_col, 1);
        check("R9 resumes count", col_count, 1);
        sof_only();
        sof_only();
        check("R9 count three", col_count, 3);
        bp_req = 1'b0;
        @(negedge clk);
        check("R10 release clears", col_count, 0);
        sof_only();
        check("R10 released no col", force_col, 0);

        finish_run();
    end
endmodule